// File: doc/BRIEF.md
# Sv39 Page Table Walker

This block turns one virtual address into a physical address by reading a three-level page table out of memory, one entry at a time. A requester presents the address together with the kind of access (instruction fetch, data load or data store), the privilege the access runs at, and two permission-relaxing control bits: one lets supervisor code touch user pages, the other lets loads read execute-only pages. The translation-control inputs supply a mode field and the physical page number of the root table.

The walker owns a single-beat memory port for page-table entries. It reads entries from the root downward. At the leaf it checks the entry's legality and the access permissions. When the leaf's accessed or dirty flag has to change, it writes the updated entry back before it answers. It returns the physical address, the read/write/execute rights that the leaf grants, and a fault flag. Only one walk is in progress at a time.

Top module: `sv39_walker`

## Requirements
- R1: When `satp_mode` is 0 (bare), or when `req_priv` is 3 (M), the walker performs no memory access. One cycle after it accepts the request it returns `rsp_paddr` equal to the low 56 bits of the virtual address, with `rsp_r`, `rsp_w` and `rsp_x` all 1. Any non-zero mode selects the translated walk. Privilege codes are 0 U, 1 S, 3 M. Access codes are 0 fetch, 1 load, 2 store.
- R2: A translated request whose address bits 63 down to 38 are not all equal faults, and no memory access is made.
- R3: The walk starts at level 2 from the root page number. The entry address at each level is the table page number times 4096, plus 8 times the 9-bit index taken from address bits [38:30], [29:21] or [20:12] for levels 2, 1 and 0. A pointer entry gives the page number of the next table down.
- R4: Entry bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7, and the page number sits in bits [53:10]. An entry with V=0 faults. An entry with V=1 and R=W=X=0 is a pointer; a pointer found at level 0 faults.
- R5: A leaf that has W set and R clear faults. This covers both W-only and W with X.
- R6: A leaf with U=1 faults when the privilege is not U and either the supervisor-user bit is clear or the access is a fetch. A leaf with U=0 faults when the privilege is not S.
- R7: A leaf found at level 1 or 2 faults if the low 9 or 18 bits of its page number are not zero.
- R8: A load needs R, or needs X with the execute-readable bit set. A store needs W. A fetch needs X. Otherwise the request faults.
- R9: On a successful walk the leaf is rewritten at its own address with A set, and with D also set for a store. The write happens only if these changes alter the entry. The response follows the write.
- R10: The physical address is the leaf page number with the low 9 bits per level above 0 replaced by the matching virtual page bits, followed by the 12-bit page offset.
- R11: An error response on a table-entry read ends the walk with a fault.
- R12: A successful walk reports r = R or (X and execute-readable), x = X, and w = W and (store or D). A faulting response carries zero permissions. `rsp_valid` is a single-cycle pulse, and `req_ready` is low while a memory access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Effective privilege: 0 U, 1 S, 3 M |
| req_sum | input | 1 | Supervisor may access user pages |
| req_mxr | input | 1 | Loads may read execute-only pages |
| satp_mode | input | 4 | Translation mode, 0 is bare |
| satp_ppn | input | 44 | Root table page number |
| mem_req | output | 1 | Memory access open, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 56 | Byte address of the table entry |
| mem_wdata | output | 64 | Entry to write |
| mem_ack | input | 1 | Memory completes the open access |
| mem_err | input | 1 | Memory reports an error with the acknowledge |
| mem_rdata | input | 64 | Entry read, valid with the acknowledge |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 56 | Physical address |
| rsp_r | output | 1 | Read permission |
| rsp_w | output | 1 | Write permission |
| rsp_x | output | 1 | Execute permission |

## Verification
The properties assume a well-behaved memory side. `mem_ack` is raised only while `mem_req` is open, it lasts one cycle, and `mem_rdata` and `mem_err` are valid in that same cycle. The properties also assume that requests are offered only while `req_ready` is high. The bench memory model acknowledges an open access one cycle after seeing it, drops the acknowledge the following cycle, and serves entries from a sparse table whose error addresses are planted on purpose. The stimulus waits for each response before it offers the next request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // entry flag positions, fixed by the table format
  localparam int B_V     = 0;
  localparam int B_R     = 1;
  localparam int B_W     = 2;
  localparam int B_X     = 3;
  localparam int B_U     = 4;
  localparam int B_A     = 6;
  localparam int B_D     = 7;
  localparam int PPN_LSB = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_WRITE
  } walk_st_e;
endpackage

// File: rtl/ptw_va_check.sv
module ptw_va_check #(
  parameter int VA_W = 64,
  parameter int TV_W = 39
) (
  input  logic [VA_W-TV_W:0] va_hi,
  output logic               canon
);
  // all bits above the translated width plus its top bit must agree
  assign canon = (&va_hi) | ~(|va_hi);
endmodule

// File: rtl/ptw_pa_merge.sv
module ptw_pa_merge #(
  parameter int LEVELS   = 3,
  parameter int IDX_W    = 9,
  parameter int PG_SHIFT = 12,
  parameter int PPN_W    = 44,
  parameter int TV_W     = 39,
  parameter int LVL_W    = 2
) (
  input  logic [PPN_W-1:0]          leaf_ppn,
  input  logic [TV_W-1:0]           va,
  input  logic [LVL_W-1:0]          lvl,
  output logic [PPN_W+PG_SHIFT-1:0] paddr,
  output logic                      misaligned
);
  localparam int VPN_W = LEVELS * IDX_W;

  logic [PPN_W-1:0] lvl_mask [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_mask
    assign lvl_mask[g] = PPN_W'((65'd1 << (g * IDX_W)) - 65'd1);
  end

  logic [PPN_W-1:0] mask;
  logic [PPN_W-1:0] vpn_ext;
  logic [PPN_W-1:0] merged;

  always_comb begin
    mask = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i)) mask = lvl_mask[i];
    end
  end

  assign vpn_ext    = PPN_W'(va[PG_SHIFT +: VPN_W]);
  assign merged     = (leaf_ppn & ~mask) | (vpn_ext & mask);
  assign paddr      = {merged, va[PG_SHIFT-1:0]};
  assign misaligned = |(leaf_ppn & mask);
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  input  logic [1:0]       priv,
  input  logic             sum,
  input  logic             mxr,
  input  logic             misaligned,
  output logic             is_ptr,
  output logic             fault,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x,
  output logic [PTE_W-1:0] upd_pte,
  output logic             need_wb
);
  logic v, r, w, x, u, d;
  logic is_store, is_load, is_fetch;
  logic reserved, priv_bad, acc_bad;

  assign v = pte[B_V];
  assign r = pte[B_R];
  assign w = pte[B_W];
  assign x = pte[B_X];
  assign u = pte[B_U];
  assign d = pte[B_D];

  assign is_store = (acc == ACC_STORE);
  assign is_load  = (acc == ACC_LOAD);
  assign is_fetch = (acc == ACC_FETCH);

  assign is_ptr   = v & ~(r | w | x);
  // W without R covers both reserved encodings
  assign reserved = w & ~r;
  assign priv_bad = u ? ((priv != PRIV_U) & (~sum | is_fetch))
                      : (priv != PRIV_S);

  always_comb begin
    acc_bad = 1'b1;
    if (is_load)       acc_bad = ~(r | (x & mxr));
    else if (is_store) acc_bad = ~w;
    else if (is_fetch) acc_bad = ~x;
  end

  assign fault = ~v | (~is_ptr & (reserved | priv_bad | misaligned | acc_bad));

  always_comb begin
    upd_pte      = pte;
    upd_pte[B_A] = 1'b1;
    if (is_store) upd_pte[B_D] = 1'b1;
  end

  assign need_wb = (upd_pte != pte);
  assign perm_r  = r | (x & mxr);
  assign perm_x  = x;
  assign perm_w  = w & (is_store | d);
endmodule

// File: rtl/sv39_walker.sv
module sv39_walker
  import ptw_pkg::*;
#(
  parameter int              VA_W      = 64,
  parameter int              LEVELS    = 3,
  parameter int              IDX_W     = 9,
  parameter int              PG_SHIFT  = 12,
  parameter int              PTE_W     = 64,
  parameter int              PPN_W     = 44,
  parameter int              MODE_W    = 4,
  parameter logic [MODE_W-1:0] MODE_BARE = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic [1:0]          req_acc,
  input  logic [1:0]          req_priv,
  input  logic                req_sum,
  input  logic                req_mxr,
  input  logic [MODE_W-1:0]   satp_mode,
  input  logic [PPN_W-1:0]    satp_ppn,
  output logic                mem_req,
  output logic                mem_we,
  output logic [PPN_W+PG_SHIFT-1:0] mem_addr,
  output logic [PTE_W-1:0]    mem_wdata,
  input  logic                mem_ack,
  input  logic                mem_err,
  input  logic [PTE_W-1:0]    mem_rdata,
  output logic                rsp_valid,
  output logic                rsp_fault,
  output logic [PPN_W+PG_SHIFT-1:0] rsp_paddr,
  output logic                rsp_r,
  output logic                rsp_w,
  output logic                rsp_x
);
  localparam int PA_W  = PPN_W + PG_SHIFT;
  localparam int TV_W  = PG_SHIFT + LEVELS * IDX_W;
  localparam int PTE_B = $clog2(PTE_W / 8);
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  function automatic logic [PA_W-1:0] pte_addr(input logic [PPN_W-1:0] base,
                                               input logic [TV_W-1:0]  va,
                                               input logic [LVL_W-1:0] lvl);
    logic [TV_W-1:0] sh;
    sh = va >> (PG_SHIFT + IDX_W * int'(lvl));
    return {base, {PG_SHIFT{1'b0}}} + (PA_W'(sh[IDX_W-1:0]) << PTE_B);
  endfunction

  walk_st_e          st_q, st_d;
  logic [TV_W-1:0]   va_q, va_d;
  logic [1:0]        acc_q, acc_d;
  logic [1:0]        priv_q, priv_d;
  logic              sum_q, sum_d;
  logic              mxr_q, mxr_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [PA_W-1:0]   addr_q, addr_d;
  logic [PTE_W-1:0]  pte_q, pte_d;

  logic              fin_valid, fin_fault, fin_r, fin_w, fin_x;
  logic [PA_W-1:0]   fin_paddr;

  logic              va_ok;
  logic [PA_W-1:0]   mg_paddr;
  logic              mg_misaligned;
  logic              lk_ptr, lk_fault, lk_r, lk_w, lk_x, lk_wb;
  logic [PTE_W-1:0]  lk_upd;

  ptw_va_check #(.VA_W(VA_W), .TV_W(TV_W)) u_va (
    .va_hi (req_vaddr[VA_W-1:TV_W-1]),
    .canon (va_ok)
  );

  ptw_pa_merge #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT),
    .PPN_W(PPN_W), .TV_W(TV_W), .LVL_W(LVL_W)
  ) u_merge (
    .leaf_ppn   (pte_q[PPN_LSB +: PPN_W]),
    .va         (va_q),
    .lvl        (lvl_q),
    .paddr      (mg_paddr),
    .misaligned (mg_misaligned)
  );

  ptw_leaf_check #(.PTE_W(PTE_W)) u_leaf (
    .pte        (pte_q),
    .acc        (acc_q),
    .priv       (priv_q),
    .sum        (sum_q),
    .mxr        (mxr_q),
    .misaligned (mg_misaligned),
    .is_ptr     (lk_ptr),
    .fault      (lk_fault),
    .perm_r     (lk_r),
    .perm_w     (lk_w),
    .perm_x     (lk_x),
    .upd_pte    (lk_upd),
    .need_wb    (lk_wb)
  );

  always_comb begin
    st_d      = st_q;
    va_d      = va_q;
    acc_d     = acc_q;
    priv_d    = priv_q;
    sum_d     = sum_q;
    mxr_d     = mxr_q;
    lvl_d     = lvl_q;
    addr_d    = addr_q;
    pte_d     = pte_q;
    fin_valid = 1'b0;
    fin_fault = 1'b0;
    fin_paddr = mg_paddr;
    fin_r     = lk_r;
    fin_w     = lk_w;
    fin_x     = lk_x;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_d   = req_vaddr[TV_W-1:0];
          acc_d  = req_acc;
          priv_d = req_priv;
          sum_d  = req_sum;
          mxr_d  = req_mxr;
          if (satp_mode == MODE_BARE || req_priv == PRIV_M) begin
            fin_valid = 1'b1;
            fin_paddr = req_vaddr[PA_W-1:0];
            fin_r     = 1'b1;
            fin_w     = 1'b1;
            fin_x     = 1'b1;
          end else if (!va_ok) begin
            fin_valid = 1'b1;
            fin_fault = 1'b1;
          end else begin
            lvl_d  = TOP_LVL;
            addr_d = pte_addr(satp_ppn, req_vaddr[TV_W-1:0], TOP_LVL);
            st_d   = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          if (mem_err) begin
            fin_valid = 1'b1;
            fin_fault = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            pte_d = mem_rdata;
            st_d  = ST_EVAL;
          end
        end
      end
      ST_EVAL: begin
        if (lk_fault) begin
          fin_valid = 1'b1;
          fin_fault = 1'b1;
          st_d      = ST_IDLE;
        end else if (lk_ptr) begin
          if (lvl_q == '0) begin
            fin_valid = 1'b1;
            fin_fault = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            lvl_d  = LVL_W'(lvl_q - 1'b1);
            addr_d = pte_addr(pte_q[PPN_LSB +: PPN_W], va_q, LVL_W'(lvl_q - 1'b1));
            st_d   = ST_READ;
          end
        end else if (lk_wb) begin
          pte_d = lk_upd;
          st_d  = ST_WRITE;
        end else begin
          fin_valid = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          fin_valid = 1'b1;
          fin_fault = mem_err;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      va_q      <= '0;
      acc_q     <= '0;
      priv_q    <= '0;
      sum_q     <= 1'b0;
      mxr_q     <= 1'b0;
      lvl_q     <= '0;
      addr_q    <= '0;
      pte_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_r     <= 1'b0;
      rsp_w     <= 1'b0;
      rsp_x     <= 1'b0;
    end else begin
      st_q      <= st_d;
      va_q      <= va_d;
      acc_q     <= acc_d;
      priv_q    <= priv_d;
      sum_q     <= sum_d;
      mxr_q     <= mxr_d;
      lvl_q     <= lvl_d;
      addr_q    <= addr_d;
      pte_q     <= pte_d;
      rsp_valid <= fin_valid;
      if (fin_valid) begin
        rsp_fault <= fin_fault;
        rsp_paddr <= fin_fault ? '0 : fin_paddr;
        rsp_r     <= fin_r & ~fin_fault;
        rsp_w     <= fin_w & ~fin_fault;
        rsp_x     <= fin_x & ~fin_fault;
      end
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign mem_req   = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we    = (st_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = pte_q;
endmodule

// File: rtl/sv39_walker_chk.sv
module sv39_walker_chk #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 56,
  parameter int TV_W   = 39,
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic [1:0]        req_priv,
  input logic [MODE_W-1:0] satp_mode,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [PA_W-1:0]   mem_addr,
  input logic              wb_v_bit,
  input logic              wb_a_bit,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              rsp_r,
  input logic              rsp_w,
  input logic              rsp_x
);
  logic [VA_W-TV_W:0] hi;
  logic               noncanon, taken;
  assign hi       = req_vaddr[VA_W-1:TV_W-1];
  assign noncanon = ~((&hi) | ~(|hi));
  assign taken    = req_valid & req_ready;

  a_r1_passthrough: assert property (@(posedge clk) disable iff (rst)
    taken && (satp_mode == '0 || req_priv == 2'd3)
    |=> rsp_valid && !rsp_fault && rsp_r && rsp_w && rsp_x
        && rsp_paddr == $past(req_vaddr[PA_W-1:0]));

  a_r2_noncanon_no_mem: assert property (@(posedge clk) disable iff (rst)
    taken && satp_mode != '0 && req_priv != 2'd3 && noncanon
    |=> rsp_valid && rsp_fault && !mem_req);

  a_r3_access_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r9_wb_sets_a: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> wb_a_bit && wb_v_bit);

  a_r12_fault_no_perm: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> !rsp_r && !rsp_w && !rsp_x);

  a_r12_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r12_single_walk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
endmodule

bind sv39_walker sv39_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .TV_W(TV_W), .MODE_W(MODE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_vaddr (req_vaddr),
  .req_priv  (req_priv),
  .satp_mode (satp_mode),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .wb_v_bit  (mem_wdata[0]),
  .wb_a_bit  (mem_wdata[6]),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_paddr (rsp_paddr),
  .rsp_r     (rsp_r),
  .rsp_w     (rsp_w),
  .rsp_x     (rsp_x)
);

// File: tb/sim_sv39_walker.sv
module sim_sv39_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [1:0]  req_priv = '0;
  logic        req_sum = 1'b0;
  logic        req_mxr = 1'b0;
  logic [3:0]  satp_mode = 4'd8;
  logic [43:0] satp_ppn = 44'h100;
  logic        mem_req, mem_we;
  logic [55:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x;
  logic [55:0] rsp_paddr;

  always #10 clk = ~clk;

  sv39_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .req_priv(req_priv),
    .req_sum(req_sum), .req_mxr(req_mxr), .satp_mode(satp_mode),
    .satp_ppn(satp_ppn), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_r(rsp_r),
    .rsp_w(rsp_w), .rsp_x(rsp_x)
  );

  logic [63:0] pmem [logic [55:0]];
  bit          err_set [logic [55:0]];
  int          n_cmp = 0, n_bad = 0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [55:0] wr_addr = '0;
  logic [63:0] wr_data = '0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // memory model plus per-clock monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_ack = 1'b0;
      end else begin
        chk(!(mem_req && req_ready), "R12 ready low during access", 64'(req_ready), 64'd0);
        if (mem_req && !mem_ack) begin
          mem_ack = 1'b1;
          mem_err = err_set.exists(mem_addr);
          if (mem_we) begin
            if (!mem_err) pmem[mem_addr] = mem_wdata;
            wr_cnt++;
            wr_addr = mem_addr;
            wr_data = mem_wdata;
          end else begin
            mem_rdata = pmem.exists(mem_addr) ? pmem[mem_addr] : 64'd0;
            rd_cnt++;
          end
        end else begin
          mem_ack = 1'b0;
          mem_err = 1'b0;
        end
      end
    end
  end

  function automatic logic [63:0] pte(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'b0, ppn, 2'b00, fl};
  endfunction

  function automatic logic [55:0] ent(input logic [43:0] tbl, input int idx);
    return {tbl, 12'h000} + 56'(idx * 8);
  endfunction

  function automatic logic [63:0] mkva(input int v2, input int v1, input int v0, input int off);
    logic [38:0] l;
    l = {9'(v2), 9'(v1), 9'(v0), 12'(off)};
    return {{25{l[38]}}, l};
  endfunction

  // behavioural reference of one translation
  task automatic ref_walk(input logic [63:0] va, input int acc, input int priv,
                          input bit sum, input bit mxr, input int mode,
                          output bit f, output logic [55:0] pa, output bit r,
                          output bit w, output bit x, output bit wb,
                          output logic [55:0] wa, output logic [63:0] wd);
    logic [43:0] base, lowmask, ppn;
    logic [55:0] a;
    logic [63:0] p, np;
    f = 0; pa = '0; r = 0; w = 0; x = 0; wb = 0; wa = '0; wd = '0;
    if (mode == 0 || priv == 3) begin
      pa = va[55:0]; r = 1; w = 1; x = 1;
      return;
    end
    if (!(va[63:38] == '0 || va[63:38] == '1)) begin f = 1; return; end
    base = satp_ppn;
    for (int lv = 2; lv >= 0; lv--) begin
      a = {base, 12'h000} + 56'(((va >> (12 + 9 * lv)) & 64'h1ff) * 8);
      if (err_set.exists(a)) begin f = 1; return; end
      p = pmem.exists(a) ? pmem[a] : 64'd0;
      if (!p[0]) begin f = 1; return; end
      if (p[3:1] == 3'b000) begin
        if (lv == 0) begin f = 1; return; end
        base = p[53:10];
        continue;
      end
      if (p[2] && !p[1]) begin f = 1; return; end
      if (p[4]) begin
        if (priv != 0 && (!sum || acc == 0)) begin f = 1; return; end
      end else if (priv != 1) begin f = 1; return; end
      lowmask = (44'd1 << (9 * lv)) - 44'd1;
      if ((p[53:10] & lowmask) != 0) begin f = 1; return; end
      if (acc == 1 && !(p[1] || (p[3] && mxr))) begin f = 1; return; end
      if (acc == 2 && !p[2]) begin f = 1; return; end
      if (acc == 0 && !p[3]) begin f = 1; return; end
      np = p | 64'h40 | ((acc == 2) ? 64'h80 : 64'h0);
      if (np != p) begin wb = 1; wa = a; wd = np; end
      ppn = (p[53:10] & ~lowmask) | ({17'b0, va[38:12]} & lowmask);
      pa = {ppn, va[11:0]};
      r = p[1] | (p[3] & mxr);
      x = p[3];
      w = p[2] & (acc == 2 || p[7]);
      return;
    end
    f = 1;
  endtask

  task automatic run(input string tag, input logic [63:0] va, input int acc,
                     input int priv, input bit sum, input bit mxr, input int mode);
    bit ef, er, ew, ex, ewb;
    logic [55:0] epa, ewa;
    logic [63:0] ewd;
    int rd0, wr0;
    ref_walk(va, acc, priv, sum, mxr, mode, ef, epa, er, ew, ex, ewb, ewa, ewd);
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_acc   = 2'(acc);
    req_priv  = 2'(priv);
    req_sum   = sum;
    req_mxr   = mxr;
    satp_mode = 4'(mode);
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 200 && !rsp_valid; t++) @(negedge clk);
    if (!rsp_valid) begin
      chk(0, {tag, " no response"}, 64'd0, 64'd1);
      return;
    end
    chk(rsp_fault == ef, {tag, " fault"}, 64'(rsp_fault), 64'(ef));
    if (!ef) begin
      chk(rsp_paddr == epa, {tag, " paddr"}, 64'(rsp_paddr), 64'(epa));
      chk({rsp_r, rsp_w, rsp_x} == {er, ew, ex}, {tag, " R12 rwx"},
          64'({rsp_r, rsp_w, rsp_x}), 64'({er, ew, ex}));
    end else begin
      chk({rsp_r, rsp_w, rsp_x} == 3'b000, {tag, " R12 fault rwx"},
          64'({rsp_r, rsp_w, rsp_x}), 64'd0);
    end
    chk((wr_cnt - wr0) == (ewb ? 1 : 0), {tag, " R9 write count"},
        64'(wr_cnt - wr0), 64'(ewb));
    if (ewb) begin
      chk(wr_addr == ewa, {tag, " R9 write addr"}, 64'(wr_addr), 64'(ewa));
      chk(wr_data == ewd, {tag, " R9 write data"}, wr_data, ewd);
    end
    if (ef && (mode != 0) && (priv != 3) && !(va[63:38] == '0 || va[63:38] == '1))
      chk(rd_cnt == rd0, {tag, " R2 no read"}, 64'(rd_cnt - rd0), 64'd0);
    @(negedge clk);
    chk(!rsp_valid, {tag, " R12 single pulse"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // tables: root 0x100, level-1 0x101 and 0x103, level-0 0x102
    pmem[ent(44'h100, 1)]   = pte(44'h101, 8'h01);
    pmem[ent(44'h101, 2)]   = pte(44'h102, 8'h01);
    pmem[ent(44'h102, 0)]   = pte(44'h5000, 8'h43);
    pmem[ent(44'h102, 1)]   = pte(44'h5001, 8'h07);
    pmem[ent(44'h102, 2)]   = pte(44'h5002, 8'h0E);
    pmem[ent(44'h102, 3)]   = pte(44'h5003, 8'h01);
    pmem[ent(44'h102, 4)]   = pte(44'h5004, 8'h45);
    pmem[ent(44'h102, 5)]   = pte(44'h5005, 8'h4D);
    pmem[ent(44'h102, 6)]   = pte(44'h5006, 8'hD7);
    pmem[ent(44'h102, 7)]   = pte(44'h5007, 8'h49);
    err_set[ent(44'h102, 8)] = 1'b1;
    pmem[ent(44'h102, 9)]   = pte(44'h5009, 8'hCF);
    pmem[ent(44'h100, 2)]   = pte(44'h40000, 8'hC7);
    pmem[ent(44'h100, 3)]   = pte(44'h103, 8'h01);
    pmem[ent(44'h103, 0)]   = pte(44'h201, 8'h43);
    pmem[ent(44'h103, 1)]   = pte(44'h400, 8'h4B);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R12 reset req_ready", 64'(req_ready), 64'd1);
    chk(mem_req == 1'b0, "R12 reset mem_req", 64'(mem_req), 64'd0);

    run("R1 bare mode",       64'h0000_1234_5678_9ABC, 1, 1, 0, 0, 0);
    run("R1 M privilege",     64'hFFFF_FF00_0000_4321, 2, 3, 0, 0, 8);
    run("R2 noncanonical",    64'h0000_0040_0000_1000, 1, 1, 0, 0, 8);
    run("R2 high ones",       64'h8000_0000_0000_0000, 1, 1, 0, 0, 8);
    run("R3 4K load",         mkva(1, 2, 0, 12'h345), 1, 1, 0, 0, 8);
    run("R9 store sets A D",  mkva(1, 2, 1, 12'h010), 2, 1, 0, 0, 8);
    run("R9 reload no write", mkva(1, 2, 1, 12'h018), 1, 1, 0, 0, 8);
    run("R4 V clear",         mkva(1, 2, 2, 0), 1, 1, 0, 0, 8);
    run("R4 pointer at last", mkva(1, 2, 3, 0), 1, 1, 0, 0, 8);
    run("R4 negative va",     mkva(9'h1FF, 0, 0, 0), 1, 1, 0, 0, 8);
    run("R5 W only",          mkva(1, 2, 4, 0), 1, 1, 0, 0, 8);
    run("R5 W plus X",        mkva(1, 2, 5, 0), 0, 1, 0, 0, 8);
    run("R6 U page S nosum",  mkva(1, 2, 6, 0), 1, 1, 0, 0, 8);
    run("R6 U page S sum",    mkva(1, 2, 6, 8), 1, 1, 1, 0, 8);
    run("R6 U page S fetch",  mkva(1, 2, 6, 0), 0, 1, 1, 0, 8);
    run("R6 U page U store",  mkva(1, 2, 6, 0), 2, 0, 0, 0, 8);
    run("R6 S page from U",   mkva(1, 2, 0, 0), 1, 0, 0, 0, 8);
    run("R8 X only no mxr",   mkva(1, 2, 7, 0), 1, 1, 0, 0, 8);
    run("R8 X only with mxr", mkva(1, 2, 7, 4), 1, 1, 0, 1, 8);
    run("R8 store to R only", mkva(1, 2, 0, 0), 2, 1, 0, 0, 8);
    run("R8 fetch no X",      mkva(1, 2, 0, 0), 0, 1, 0, 0, 8);
    run("R8 fetch with X",    mkva(1, 2, 9, 12'hFFC), 0, 1, 0, 0, 8);
    run("R11 read error",     mkva(1, 2, 8, 0), 1, 1, 0, 0, 8);
    run("R10 1G superpage",   mkva(2, 5, 7, 12'h123), 2, 1, 0, 0, 8);
    run("R7 2M misaligned",   mkva(3, 0, 9, 0), 1, 1, 0, 0, 8);
    run("R10 2M superpage",   mkva(3, 1, 12'h0AB, 12'h777), 0, 1, 0, 0, 8);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule